// File: doc/BRIEF.md
# Packed palette index and data port

This block sits between a 32-bit register bus and a 256-entry colour lookup table. Software sees three word registers. The first is an index word that holds a palette read pointer and a palette write pointer side by side. The second is a data word. The third is a colour-converter control word. The lookup table itself is a plain array with one slot per colour component, and it is part of the block.

A single write to the data word delivers a whole red/green/blue triple. The block splits that triple into three ordered component writes to the entry under the write pointer. The write pointer then moves on by one. Reads of the data word work one component at a time, in the same red, green, blue order. The read pointer advances after every third component. A control bit selects between full 8-bit components and a 6-bit mode, in which only the low six bits are kept and returned.

Accesses may be narrow (1 or 2 bytes) at any byte offset inside a word. The block applies byte-lane rules that depend on the register: the index word decides by offset which pointer a narrow write loads. The data word shifts a narrow write's data before it takes the components apart.

Top module: `pal_port`

## Requirements
- R1: After reset the write pointer, read pointer, read component counter and control word are all zero, `rd_valid` is 0 and `rdata` is zero.
- R2: Reading the index word (word 0, byte address 0x0) returns the read pointer in bits 23:16 and the write pointer in bits 7:0, with every other bit zero.
- R3: A 4-byte write to the index word at offset 0 loads the read pointer from `wdata[23:16]` and the write pointer from `wdata[7:0]`, and it restarts the read component counter at red.
- R4: A narrow write (`size` 0 = 1 byte, 1 = 2 bytes) to the index word at byte offset 0 loads only the write pointer from `wdata[7:0]`. At any other offset it loads only the read pointer from `wdata[7:0]` and restarts the read component counter. Narrow write data is right-aligned in `wdata`.
- R5: A write to the data word (word 1, byte address 0x4) stores red from bits 23:16, green from 15:8 and blue from 7:0 of the data into the entry at the write pointer. The write pointer then advances by one and wraps from 255 to 0.
- R6: For a data-word write of `size` bytes at byte offset k, the data is first cut to its low `size` bytes (`size` 2 or 3 = 4 bytes) and then shifted left by k bit positions before the components are taken.
- R7: Each read of the data word returns one component of the entry at the read pointer in `rdata[7:0]`, with the upper bits zero, in the order red, green, blue. After the blue read the read pointer advances by one, wrapping from 255 to 0. Size and offset do not change this.
- R8: Control bit 8 set selects 8-bit components. When it is clear, data writes store only the low 6 bits of each component and data reads return only the low 6 bits.
- R9: A write to the control word (word 2, byte address 0x8) deposits its bytes at the addressed lanes, and bits 12:10 are always stored as zero. A read returns the stored value.
- R10: A narrow read of the index or control word returns that word shifted right by 8×offset bits and cut to `size` bytes.
- R11: Writes to word 3 (byte address 0xC) change no state, and reads of it return zero.
- R12: A read accepted at a clock edge (`rd_en` high, `wr_en` low) gives `rd_valid` high with `rdata` for exactly the following cycle. When `rd_en` and `wr_en` are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address: bits above 1 pick the word, bits 1:0 the byte offset |
| size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, otherwise 4 bytes |
| wdata | input | 32 | Write data, right-aligned for narrow accesses |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when `rdata` carries a read result |

## Verification
The bench builds the block with its defaults: a 4-bit address, 256 entries and 8-bit component storage. With 256 entries, the wrap of both pointers from 255 to 0 is reachable by filling the table once. With 8-bit storage, the difference between the 8-bit and 6-bit modes shows in stored and returned values. Random phases mix narrow and wide accesses at every offset against the lane rules of each word, and directed cases cover the pointer wraps, the shifted narrow data write and the reserved control bits.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int BUS_W = 32;

    // word selects decoded from the byte address
    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // control word: component width select and reserved lanes
    localparam int                 CTRL_WIDE_BIT = 8;
    localparam logic [BUS_W-1:0]   CTRL_KEEP     = 32'hFFFF_E3FF;

    // number of colour components per entry
    localparam int NCOMP = 3;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] offs;
        logic [2:0] nbytes;
        logic       full;
    } access_t;

    function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] low_mask(input logic [2:0] nb);
        case (nb)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] offs,
                                                   input logic [2:0] nb);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int b = 0; b < 4; b++) begin
            if (b >= int'(offs) && b < int'(offs) + int'(nb))
                m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

    function automatic logic [BUS_W-1:0] deposit(input logic [BUS_W-1:0] old,
                                                 input logic [BUS_W-1:0] data,
                                                 input logic [1:0]       offs,
                                                 input logic [2:0]       nb);
        logic [BUS_W-1:0] m;
        logic [BUS_W-1:0] sh;
        m  = lane_mask(offs, nb);
        sh = data << {offs, 3'b000};
        return (old & ~m) | (sh & m);
    endfunction

    function automatic logic [BUS_W-1:0] extract(input logic [BUS_W-1:0] full,
                                                 input logic [1:0]       offs,
                                                 input logic [2:0]       nb);
        return (full >> {offs, 3'b000}) & low_mask(nb);
    endfunction

endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode
    import pal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output access_t           acc
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;

    assign word = addr[ADDR_W-1:2];

    always_comb begin
        acc.offs   = addr[1:0];
        acc.nbytes = size_to_bytes(size);
        acc.full   = (addr[1:0] == 2'd0) && (size_to_bytes(size) == 3'd4);
        if (word == WORD_W'(0))
            acc.sel = SEL_INDEX;
        else if (word == WORD_W'(1))
            acc.sel = SEL_DATA;
        else if (word == WORD_W'(2))
            acc.sel = SEL_CTRL;
        else
            acc.sel = SEL_NONE;
    end
endmodule

// File: rtl/pal_index_ctrl.sv
module pal_index_ctrl #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_wr,
    input  logic             full,
    input  logic             offs_zero,
    input  logic [7:0]       lo_byte,
    input  logic [7:0]       hi_byte,
    input  logic             data_wr,
    input  logic             data_rd,
    output logic [IDX_W-1:0] widx,
    output logic [IDX_W-1:0] ridx,
    output logic [1:0]       rcnt
);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);
    localparam logic [1:0]       LAST_CMP = 2'd2;

    always_ff @(posedge clk) begin
        if (rst) begin
            widx <= '0;
            ridx <= '0;
            rcnt <= '0;
        end else if (idx_wr) begin
            if (full) begin
                widx <= lo_byte[IDX_W-1:0];
                ridx <= hi_byte[IDX_W-1:0];
                rcnt <= '0;
            end else if (offs_zero) begin
                widx <= lo_byte[IDX_W-1:0];
            end else begin
                ridx <= lo_byte[IDX_W-1:0];
                rcnt <= '0;
            end
        end else begin
            if (data_wr)
                widx <= widx + IDX_ONE;
            if (data_rd) begin
                if (rcnt == LAST_CMP) begin
                    rcnt <= '0;
                    ridx <= ridx + IDX_ONE;
                end else begin
                    rcnt <= rcnt + 2'd1;
                end
            end
        end
    end

    // R5
    widx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !idx_wr) |=> (widx == $past(widx) + IDX_ONE));

    // R7
    ridx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !idx_wr && rcnt == LAST_CMP) |=> (ridx == $past(ridx) + IDX_ONE && rcnt == 2'd0));

    // R7
    ridx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !idx_wr && rcnt != LAST_CMP) |=> (ridx == $past(ridx)));

    // R4
    widx_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && !full && !offs_zero) |=> (widx == $past(widx)));
endmodule

// File: rtl/pal_lut_ram.sv
module pal_lut_ram
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8,
    parameter int COMP_W  = 8
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [IDX_W-1:0]              waddr,
    input  logic [NCOMP-1:0][COMP_W-1:0]  wcomp,
    input  logic [IDX_W-1:0]              raddr,
    output logic [NCOMP-1:0][COMP_W-1:0]  rcomp
);
    for (genvar c = 0; c < NCOMP; c++) begin : g_comp
        logic [COMP_W-1:0] mem [ENTRIES];

        always_ff @(posedge clk) begin
            if (we)
                mem[waddr] <= wcomp[c];
        end

        assign rcomp[c] = mem[raddr];
    end
endmodule

// File: rtl/pal_port.sv
module pal_port
    import pal_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int ENTRIES = 256,
    parameter int COMP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rd_valid
);
    localparam int                IDX_W   = $clog2(ENTRIES);
    localparam logic [COMP_W-1:0] NARROW6 = COMP_W'(6'h3F);

    access_t                      acc;
    logic                         rd_go;
    logic                         idx_wr, data_wr, ctrl_wr, data_rd;
    logic [IDX_W-1:0]             widx, ridx;
    logic [1:0]                   rcnt;
    logic [31:0]                  ctrl_q;
    logic                         wide;
    logic [COMP_W-1:0]            cmask;
    logic [31:0]                  trimmed, shifted;
    logic [NCOMP-1:0][COMP_W-1:0] wcomp, rcomp;
    logic [31:0]                  index_word;
    logic [31:0]                  rd_word;
    logic [31:0]                  rdata_q;
    logic                         rd_valid_q;

    pal_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .size (size),
        .acc  (acc)
    );

    assign rd_go   = rd_en && !wr_en;
    assign idx_wr  = wr_en && acc.sel == SEL_INDEX;
    assign data_wr = wr_en && acc.sel == SEL_DATA;
    assign ctrl_wr = wr_en && acc.sel == SEL_CTRL;
    assign data_rd = rd_go && acc.sel == SEL_DATA;

    pal_index_ctrl #(.IDX_W(IDX_W)) u_idx (
        .clk       (clk),
        .rst       (rst),
        .idx_wr    (idx_wr),
        .full      (acc.full),
        .offs_zero (acc.offs == 2'd0),
        .lo_byte   (wdata[7:0]),
        .hi_byte   (wdata[23:16]),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .widx      (widx),
        .ridx      (ridx),
        .rcnt      (rcnt)
    );

    // control word with reserved lanes held at zero
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= deposit(ctrl_q, wdata, acc.offs, acc.nbytes) & CTRL_KEEP;
    end

    assign wide  = ctrl_q[CTRL_WIDE_BIT];
    assign cmask = wide ? '1 : NARROW6;

    // data word: trim to access size, shift by offset bits, split red/green/blue
    assign trimmed = wdata & low_mask(acc.nbytes);
    assign shifted = trimmed << acc.offs;

    always_comb begin
        for (int c = 0; c < NCOMP; c++) begin
            wcomp[c] = shifted[(NCOMP-1-c)*8 +: COMP_W] & cmask;
        end
    end

    pal_lut_ram #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .COMP_W  (COMP_W)
    ) u_ram (
        .clk   (clk),
        .we    (data_wr),
        .waddr (widx),
        .wcomp (wcomp),
        .raddr (ridx),
        .rcomp (rcomp)
    );

    assign index_word = {8'h00, 8'(ridx), 8'h00, 8'(widx)};

    always_comb begin
        case (acc.sel)
            SEL_INDEX: rd_word = extract(index_word, acc.offs, acc.nbytes);
            SEL_DATA:  rd_word = 32'(rcomp[rcnt] & cmask);
            SEL_CTRL:  rd_word = extract(ctrl_q, acc.offs, acc.nbytes);
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_go;
            if (rd_go)
                rdata_q <= rd_word;
        end
    end

    assign rdata    = rdata_q;
    assign rd_valid = rd_valid_q;

    // R12
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> rd_valid);

    // R12
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> !rd_valid);

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl_q));

    // R8
    narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !wide) |=> (rdata[31:6] == '0));

    // R7
    comp_read_chk: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> (rdata[31:8] == '0));
endmodule

// File: tb/tb_pal_port.sv
module tb_pal_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [7:0]  m_widx, m_ridx;
    int          m_rcnt;
    logic [31:0] m_ctrl;
    logic [7:0]  m_pal [256][3];

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_port dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .size     (size),
        .wdata    (wdata),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    function automatic int nb(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] lowm(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] f_extract(input logic [31:0] w, input logic [1:0] o,
                                              input logic [1:0] sz);
        return (w >> (8*o)) & lowm(sz);
    endfunction

    function automatic logic [31:0] f_deposit(input logic [31:0] old, input logic [31:0] d,
                                              input logic [1:0] o, input logic [1:0] sz);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++)
            if (b >= o && b < o + nb(sz))
                r[b*8 +: 8] = d[(b-o)*8 +: 8];
        return r;
    endfunction

    function automatic logic [7:0] cmask();
        return m_ctrl[8] ? 8'hFF : 8'h3F;
    endfunction

    function automatic logic [31:0] idx_word();
        return {8'h00, m_ridx, 8'h00, m_widx};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; size = sz; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a; size = sz;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
        check("R12 rd_valid after read", {31'b0, rd_valid}, 32'd1);
    endtask

    // model-updating operations
    task automatic w_index(input logic [1:0] o, input logic [1:0] sz, input logic [31:0] d);
        bus_write({2'd0, o}, sz, d);
        if (o == 2'd0 && nb(sz) == 4) begin
            m_widx = d[7:0]; m_ridx = d[23:16]; m_rcnt = 0;
        end else if (o == 2'd0) begin
            m_widx = d[7:0];
        end else begin
            m_ridx = d[7:0]; m_rcnt = 0;
        end
    endtask

    task automatic w_data(input logic [1:0] o, input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] sh;
        bus_write({2'd1, o}, sz, d);
        sh = (d & lowm(sz)) << o;
        m_pal[m_widx][0] = sh[23:16] & cmask();
        m_pal[m_widx][1] = sh[15:8]  & cmask();
        m_pal[m_widx][2] = sh[7:0]   & cmask();
        m_widx = m_widx + 8'd1;
    endtask

    task automatic w_ctrl(input logic [1:0] o, input logic [1:0] sz, input logic [31:0] d);
        bus_write({2'd2, o}, sz, d);
        m_ctrl = f_deposit(m_ctrl, d, o, sz) & 32'hFFFF_E3FF;
    endtask

    task automatic r_index(input string req, input logic [1:0] o, input logic [1:0] sz);
        logic [31:0] d;
        bus_read({2'd0, o}, sz, d);
        check(req, d, f_extract(idx_word(), o, sz));
    endtask

    task automatic r_ctrl(input string req, input logic [1:0] o, input logic [1:0] sz);
        logic [31:0] d;
        bus_read({2'd2, o}, sz, d);
        check(req, d, f_extract(m_ctrl, o, sz));
    endtask

    task automatic r_data(input string req, input logic [1:0] o, input logic [1:0] sz);
        logic [31:0] d;
        bus_read({2'd1, o}, sz, d);
        check(req, d, {24'h0, m_pal[m_ridx][m_rcnt] & cmask()});
        if (m_rcnt == 2) begin
            m_rcnt = 0; m_ridx = m_ridx + 8'd1;
        end else begin
            m_rcnt++;
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; size = '0; wdata = '0;
        m_widx = '0; m_ridx = '0; m_rcnt = 0; m_ctrl = '0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 rd_valid at reset", {31'b0, rd_valid}, 32'd0);
        check("R1 rdata at reset", rdata, 32'd0);
        r_index("R1 R2 index word after reset", 2'd0, 2'd2);
        r_ctrl("R1 control word after reset", 2'd0, 2'd2);
        @(negedge clk);
        check("R12 rd_valid drops", {31'b0, rd_valid}, 32'd0);

        // R9 reserved control bits
        w_ctrl(2'd0, 2'd2, 32'hFFFF_FFFF);
        r_ctrl("R9 control reserved bits cleared", 2'd0, 2'd2);
        w_ctrl(2'd0, 2'd2, 32'h0000_0100);
        w_ctrl(2'd2, 2'd0, 32'h0000_00A5);
        r_ctrl("R9 narrow control deposit", 2'd0, 2'd2);
        r_ctrl("R10 narrow control read", 2'd2, 2'd0);

        // R5 fill whole table in 8-bit mode, write pointer wraps
        w_index(2'd0, 2'd2, 32'h0000_0000);
        for (int i = 0; i < 256; i++)
            w_data(2'd0, 2'd2, {8'h00, 8'(i), 8'(~i), 8'(i ^ 8'h5A)});
        r_index("R5 write pointer wraps to zero", 2'd0, 2'd2);

        // R3 full index write, R7 component order
        w_index(2'd0, 2'd2, 32'h0010_0020);
        r_index("R3 R2 full index load", 2'd0, 2'd2);
        r_data("R7 red component", 2'd0, 2'd0);
        r_data("R7 green component", 2'd3, 2'd1);
        r_data("R7 blue component", 2'd0, 2'd2);
        r_index("R7 read pointer advanced after blue", 2'd0, 2'd2);

        // R4 narrow index writes, R7 read pointer wrap
        w_index(2'd2, 2'd0, 32'h0000_00FF);
        r_index("R4 narrow offset 2 loads read pointer only", 2'd0, 2'd2);
        for (int i = 0; i < 3; i++) r_data("R7 entry 255 component", 2'd0, 2'd2);
        r_index("R7 read pointer wraps to zero", 2'd0, 2'd2);
        w_index(2'd0, 2'd1, 32'h0000_1234);
        r_index("R4 narrow offset 0 loads write pointer only", 2'd0, 2'd2);
        r_index("R10 narrow index read offset 2", 2'd2, 2'd0);
        r_index("R10 narrow index read offset 1", 2'd1, 2'd1);

        // R4 narrow read-pointer write restarts component counter
        w_index(2'd1, 2'd0, 32'h0000_0030);
        r_data("R4 counter restart first read", 2'd0, 2'd0);
        w_index(2'd3, 2'd0, 32'h0000_0030);
        r_data("R4 counter restarted to red", 2'd0, 2'd0);

        // R6 narrow data write with bit shift
        w_data(2'd1, 2'd0, 32'h0000_0080);
        w_data(2'd3, 2'd1, 32'h0000_F0F1);
        w_index(2'd1, 2'd0, 32'h0000_0034);
        for (int i = 0; i < 6; i++) r_data("R6 shifted narrow data component", 2'd0, 2'd0);

        // R8 6-bit mode
        w_ctrl(2'd1, 2'd0, 32'h0000_0000);
        w_data(2'd0, 2'd2, 32'h00FF_C3A5);
        w_index(2'd1, 2'd0, 32'h0000_0036);
        for (int i = 0; i < 3; i++) r_data("R8 six-bit stored component", 2'd0, 2'd2);
        w_index(2'd1, 2'd0, 32'h0000_0001);
        for (int i = 0; i < 3; i++) r_data("R8 six-bit readback of wide entry", 2'd0, 2'd2);
        w_ctrl(2'd1, 2'd0, 32'h0000_0001);
        w_index(2'd1, 2'd0, 32'h0000_0036);
        r_data("R8 wide mode readback of narrow entry", 2'd0, 2'd2);

        // R11 unmapped word
        bus_write(4'hC, 2'd2, 32'hFFFF_FFFF);
        bus_write(4'hD, 2'd0, 32'h0000_0055);
        r_index("R11 index unchanged by unmapped write", 2'd0, 2'd2);
        r_ctrl("R11 control unchanged by unmapped write", 2'd0, 2'd2);
        bus_read(4'hC, 2'd2, d);
        check("R11 unmapped read is zero", d, 32'd0);

        // R12 simultaneous read and write: write only
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 4'h0; size = 2'd2; wdata = 32'h0007_0009;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        m_widx = 8'h09; m_ridx = 8'h07; m_rcnt = 0;
        check("R12 no read when write collides", {31'b0, rd_valid}, 32'd0);
        r_index("R12 collided write took effect", 2'd0, 2'd2);

        // random phase
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [1:0] o, sz;
            logic [31:0] r;
            op = int'($urandom_range(0, 7));
            o  = 2'($urandom_range(0, 3));
            sz = 2'($urandom_range(0, 2));
            r  = $urandom;
            case (op)
                0: w_index(2'd0, 2'd2, r);
                1: w_index(o, sz == 2'd2 ? 2'd0 : sz, r);
                2: w_data(o, sz, r);
                3: r_data("R7 R8 random data read", o, sz);
                4: r_data("R7 random data read", o, sz);
                5: r_index("R2 R10 random index read", o, sz);
                6: w_ctrl(o, sz, r);
                default: r_ctrl("R9 R10 random control read", o, sz);
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule